// File: doc/BRIEF.md
# Stride-Grouping Transpose Buffer

This block takes a frame of N×N complex samples that arrives N samples per beat in natural index order, and sends the frame back out N samples per beat in stride order. Output beat k carries every sample whose index leaves remainder k when divided by N: k, k+N, k+2N and so on up to k+N(N-1). That set is exactly what one first-stage N-point sub-transform of an N²-point FFT consumes. Seen another way, the frame is an N×N matrix written one row per beat and read one column per beat.

Storage is two frame banks used in ping-pong fashion. One bank is written while the other is drained, so a steady stream moves at one beat per cycle on each side with one frame of added latency. Each bank is spread over N lane memories with a rotated address. Every input beat then writes one word to each lane memory, and every output beat reads one word from each lane memory. The default is N=8 with 8-bit real and imaginary parts. The intended large configuration is N=64, a 4096-point frame.

Both streams use valid/ready. A beat is transferred on a rising clock edge where valid and ready are both high. `in_ready` depends only on bank occupancy and never on `in_valid`. `out_valid` depends only on bank occupancy and never on `out_ready`. Once `out_valid` is raised, the beat stays on the port unchanged until it is taken. The source may drop `in_valid` at any point inside a frame.

Top module: `stride_xpose_buf`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Input lane c occupies `in_data[c*2W +: 2W]`, with the real part in the upper W bits and the imaginary part in the lower W bits. Input lane c of beat r within a frame carries sample r*N+c. Output lane j of group beat k carries sample k+N*j of the same frame, in the same lane layout.
- R3: Each frame leaves as groups k = 0, 1, …, N-1 in that order. `out_first` is 1 exactly on group 0 while `out_valid` is 1.
- R4: No beat of a frame is offered before all N of its input beats are accepted. When the reader is otherwise idle, `out_valid` rises in the cycle right after the handshake of the frame's last input beat.
- R5: While `in_valid` is low in mid-frame, the write position is held. No sample is lost or duplicated, whatever the pattern of gaps.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged in the next cycle.
- R7: A second frame is accepted without stalls while the first is still waiting to drain. `in_ready` is low only while both banks hold unread frames. Input offered while `in_ready` is low is not stored.
- R8: With `in_valid` and `out_ready` held high, consecutive frames flow at one beat per cycle on both sides. After the first output beat there is no idle output cycle and no input stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Buffer can accept an input beat |
| in_data | input | N*2*W | N consecutive complex samples |
| out_valid | output | 1 | Output group present |
| out_ready | input | 1 | Sink takes the output group |
| out_data | output | N*2*W | N samples spaced N apart |
| out_first | output | 1 | Current group is group 0 of a frame |

## Verification
`out_valid` for a frame is due exactly one cycle after the edge that accepts the frame's last input beat. The bench records the cycle number of that handshake and compares it with the first cycle in which `out_valid` is seen. Handshakes are decided from values sampled at the falling edge, which stay put until the next rising edge, so each accepted output group is checked against the arithmetic expectation in the half-cycle before the edge that takes it. A stalled group is compared again one cycle later. Sweeps over pairs of input-gap and output-back-pressure patterns show that ordering and data depend only on handshakes, never on timing.

// File: rtl/sx_pkg.sv
package sx_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;
endpackage

// File: rtl/sx_lane_ram.sv
module sx_lane_ram #(
  parameter int WORD   = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD-1:0]   wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [WORD-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sx_wr_ctrl.sv
module sx_wr_ctrl
  import sx_pkg::*;
#(
  parameter int N = 8,
  localparam int ROW_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       full,
  output logic             in_ready,
  output logic             wr_fire,
  output bank_e            wr_bank,
  output logic [ROW_W-1:0] wr_row,
  output logic             frame_done
);
  assign in_ready   = !full[wr_bank];
  assign wr_fire    = in_valid && in_ready;
  assign frame_done = wr_fire && (wr_row == ROW_W'(N-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_row  <= '0;
      wr_bank <= BANK_A;
    end else if (wr_fire) begin
      wr_row <= wr_row + 1'b1;
      if (frame_done) wr_bank <= bank_e'(~wr_bank);
    end
  end

  // R5: a cycle without a write handshake leaves the write position alone
  assert_row_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(wr_row) && $stable(wr_bank));
endmodule

// File: rtl/sx_rd_ctrl.sv
module sx_rd_ctrl
  import sx_pkg::*;
#(
  parameter int N = 8,
  localparam int ROW_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       full,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_first,
  output logic             rd_fire,
  output bank_e            rd_bank,
  output logic [ROW_W-1:0] rd_col,
  output logic             frame_done
);
  assign out_valid  = full[rd_bank];
  assign out_first  = out_valid && (rd_col == '0);
  assign rd_fire    = out_valid && out_ready;
  assign frame_done = rd_fire && (rd_col == ROW_W'(N-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_col  <= '0;
      rd_bank <= BANK_A;
    end else if (rd_fire) begin
      rd_col <= rd_col + 1'b1;
      if (frame_done) rd_bank <= bank_e'(~rd_bank);
    end
  end

  // R8: inside a frame the next group is available right after a group is taken
  assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !frame_done) |=> out_valid);
endmodule

// File: rtl/stride_xpose_buf.sv
module stride_xpose_buf
  import sx_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8,
  localparam int SW    = 2 * W,
  localparam int ROW_W = $clog2(N),
  localparam int BUS_W = N * SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BUS_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BUS_W-1:0] out_data,
  output logic             out_first
);
  logic [1:0]       full;
  logic             wr_fire, w_done, rd_fire, r_done;
  bank_e            wr_bank, rd_bank;
  logic [ROW_W-1:0] wr_row, rd_col;
  logic [SW-1:0]    in_lane [N];
  logic [SW-1:0]    rd_word [N];
  logic [1:0]       set_v, clr_v;

  sx_wr_ctrl #(.N(N)) i_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .full(full),
    .in_ready(in_ready), .wr_fire(wr_fire), .wr_bank(wr_bank),
    .wr_row(wr_row), .frame_done(w_done)
  );

  sx_rd_ctrl #(.N(N)) i_rd (
    .clk(clk), .rst_n(rst_n), .full(full), .out_ready(out_ready),
    .out_valid(out_valid), .out_first(out_first), .rd_fire(rd_fire),
    .rd_bank(rd_bank), .rd_col(rd_col), .frame_done(r_done)
  );

  // Bank occupancy: the writer fills a bank, the reader empties the other one
  assign set_v = {w_done && (wr_bank == BANK_B), w_done && (wr_bank == BANK_A)};
  assign clr_v = {r_done && (rd_bank == BANK_B), r_done && (rd_bank == BANK_A)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= '0;
    else        full <= (full | set_v) & ~clr_v;
  end

  // Lane memory m holds row r, column (m - r) mod N at row address r.
  // Reading column k takes row (m - k) mod N from memory m.
  for (genvar m = 0; m < N; m++) begin : g_lane
    logic [ROW_W-1:0] src_lane, rd_row, out_src;
    logic [SW-1:0]    wdata;

    assign in_lane[m] = in_data[m*SW +: SW];
    assign src_lane   = ROW_W'(m) - wr_row;
    assign rd_row     = ROW_W'(m) - rd_col;
    assign wdata      = in_lane[src_lane];

    sx_lane_ram #(.WORD(SW), .ADDR_W(ROW_W + 1)) i_ram (
      .clk(clk), .we(wr_fire),
      .waddr({wr_bank, wr_row}), .wdata(wdata),
      .raddr({rd_bank, rd_row}), .rdata(rd_word[m])
    );

    // output lane m is row m of the current column
    assign out_src = ROW_W'(m) + rd_col;
    assign out_data[m*SW +: SW] = rd_word[out_src];
  end

  // R6: an offered group that is not taken stays on the port unchanged
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4: a completed input frame is offered in the following cycle
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    w_done |=> out_valid);

  // R7: the writer is only blocked when there is a frame waiting to drain
  assert_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  // R3: every new offer starts with group 0
  assert_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_first);
endmodule

// File: tb/test_stride_xpose_buf.sv
module test_stride_xpose_buf;
  localparam int N = 8;
  localparam int W = 8;
  localparam int SW = 2 * W;
  localparam int BUS_W = N * SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid, in_ready, out_valid, out_ready, out_first;
  logic [BUS_W-1:0] in_data, out_data;

  always #10 clk = ~clk;

  stride_xpose_buf #(.N(N), .W(W)) i_stride_xpose_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first)
  );

  int checks = 0, fails = 0, cyc = 0;
  int prod_frame = 0, cons_frame = 0;
  int first_done_cyc = -1, first_vld_cyc = -1;
  int in_stalls = 0, out_gaps = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && out_valid && first_vld_cyc < 0) first_vld_cyc = cyc;

  function automatic logic [SW-1:0] enc(int f, int s);
    logic [W-1:0] re, im;
    re = W'(s * 3 + f * 37);
    im = W'(s ^ (f * 11 + 90));
    return {re, im};
  endfunction

  function automatic bit gate(int p, int t);
    case (p)
      0:       return 1'b1;
      1:       return (t % 3) != 2;
      2:       return ((t * 7 + 3) % 5) < 2;
      default: return (t % 4) == 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic produce(int nf, int p);
    for (int b = 0; b < nf * N; ) begin
      bit hs;
      int now;
      @(negedge clk);
      now = cyc;
      in_valid = gate(p, b + now);
      for (int c = 0; c < N; c++)
        in_data[c*SW +: SW] = enc(prod_frame + b / N, (b % N) * N + c);
      #1;
      hs = in_valid && in_ready;
      if (in_valid && !in_ready) in_stalls++;
      @(posedge clk);
      if (hs) begin
        if (b % N == N - 1 && first_done_cyc < 0) first_done_cyc = now;
        b++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    prod_frame += nf;
  endtask

  task automatic consume(int nf, int p);
    logic [BUS_W-1:0] prev, exp;
    bit stalled = 1'b0;
    int k = 0;
    while (k < nf * N) begin
      @(negedge clk);
      out_ready = gate(p, k + cyc);
      #1;
      if (stalled) check(out_valid && out_data == prev, "R6", "held group", out_data, prev);
      stalled = 1'b0;
      if (out_valid && out_ready) begin
        for (int j = 0; j < N; j++)
          exp[j*SW +: SW] = enc(cons_frame + k / N, (k % N) + N * j);
        check(out_first == (k % N == 0), "R3", "group-0 marker", BUS_W'(out_first), BUS_W'(k % N == 0));
        check(out_data == exp, "R2", "stride group", out_data, exp);
        k++;
      end else if (out_valid) begin
        stalled = 1'b1;
        prev = out_data;
      end else if (out_ready && k > 0) begin
        out_gaps++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    cons_frame += nf;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog expired: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    in_valid = 1'b0;
    out_ready = 1'b0;
    in_data = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R1", "in reset valid/ready", BUS_W'({out_valid, in_ready}), BUS_W'(2'b01));
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", "after reset valid/ready", BUS_W'({out_valid, in_ready}), BUS_W'(2'b01));

    // R4 and R7: two frames written with no sink
    in_stalls = 0;
    produce(2, 0);
    check(first_vld_cyc == first_done_cyc + 1, "R4", "first offer cycle",
          BUS_W'(first_vld_cyc), BUS_W'(first_done_cyc + 1));
    check(in_stalls == 0, "R7", "second frame stalls", BUS_W'(in_stalls), '0);
    check(!in_ready && out_valid, "R7", "both banks full", BUS_W'({in_ready, out_valid}), BUS_W'(2'b01));
    // offer junk while blocked; it must not be stored
    @(negedge clk);
    in_valid = 1'b1;
    in_data = '1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    consume(2, 0);

    // R8: continuous streaming at full rate
    in_stalls = 0;
    out_gaps = 0;
    fork
      produce(4, 0);
      consume(4, 0);
    join
    check(in_stalls == 0, "R8", "input stalls at full rate", BUS_W'(in_stalls), '0);
    check(out_gaps == 0, "R8", "output gaps at full rate", BUS_W'(out_gaps), '0);

    // R5 and R6: sweep of input gaps against output back-pressure
    for (int pi = 0; pi < 4; pi++)
      for (int po = 0; po < 4; po++)
        fork
          produce(2, pi);
          consume(2, po);
        join
    check(prod_frame == cons_frame, "R5", "frames in vs out", BUS_W'(cons_frame), BUS_W'(prod_frame));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule